// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat in one read or write burst of a synchronous DRAM. A start request loads a starting column together with the burst-length code and the ordering flag (linear or interleaved). From the next clock on, the block drives one column address per cycle for as long as the burst runs. A bounded burst ends by itself after its last beat. A full-page burst wraps around the row until a terminate request stops it.

A terminate request may arrive on any cycle and stops the burst after the address shown in that cycle. A new start may also arrive on any cycle. It drops the running burst and restarts the sequence from the new column on the very next cycle, with no minimum gap between starts. The block marks the final beat of a bounded burst and pulses a completion flag in the cycle after a burst ends. Data, CAS latency and mode programming are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held (active-low `rst_n`) and in the first cycle after it, `beat_vld`, `beat_last` and `burst_done` are low.
- R2: A start sampled at a clock edge makes `beat_vld` high in the following cycle, with `beat_col` equal to the sampled `start_col`.
- R3: With `ileave` low and `len_code` 0, 1, 2 or 3, the burst has 1, 2, 4 or 8 beats. The low log2(length) bits of the column count up by one per beat modulo the length, and the upper bits keep their starting value.
- R4: With `ileave` low and `len_code` 4 to 7 (full page), the column counts up by one per beat modulo 512 and keeps running until a terminate or a new start. `beat_last` is never raised.
- R5: With `ileave` high, the low log2(length) bits of beat k equal the starting low bits XOR k, and the upper bits stay fixed.
- R6: With `ileave` high and a full-page `len_code` (4 to 7), the burst runs as an 8-beat interleaved burst.
- R7: `beat_last` is high exactly on the final beat of a bounded burst. If no new start arrives in that cycle, `beat_vld` is low in the cycle after.
- R8: `burst_done` is high for one cycle, in the cycle after a final beat or after a terminate accepted during a beat, unless a start was sampled in that same cycle.
- R9: A terminate sampled during a beat makes `beat_vld` low in the next cycle. A terminate while idle has no effect: `beat_vld` and `burst_done` stay low.
- R10: A start sampled during a running burst restarts from the new column in the next cycle. When start and terminate arrive together, the start wins.
- R11: `len_code` and `ileave` are sampled only on start. Changing them during a burst does not alter its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst (overrides a running one) |
| start_col | input | 9 | First column of the burst |
| len_code | input | 3 | 0..3: 1/2/4/8 beats; 4..7: full page |
| ileave | input | 1 | 1 = interleaved ordering, 0 = linear ordering |
| term | input | 1 | Stop the running burst |
| beat_col | output | 9 | Column address of the current beat |
| beat_vld | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Current beat is the last of a bounded burst |
| burst_done | output | 1 | One-cycle pulse after a burst ends |

## Verification
Two collisions decide most of the control behaviour. The first is a new start landing in the same cycle as the final beat or as a terminate. The second is a terminate landing on the last beat. The bench drives starts and terminates on chosen beats, including the last beat of bounded bursts and both requests together. A behavioural model built from integers and modulo arithmetic decides each cycle whether the burst restarts, ends or completes, and whether the completion pulse is suppressed. It then compares address, valid, last and done on every clock.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ileave,
  input  logic             term,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_vld,
  output logic             beat_last,
  output logic             burst_done
);

  logic             act_q, il_q, full_q, done_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] mask_in, low_seq, low_il;
  logic             full_in;

  assign full_in = len_code[2] & ~ileave;

  always_comb begin
    if (full_in)          mask_in = '1;
    else if (len_code[2]) mask_in = COL_W'(7);
    else                  mask_in = (COL_W'(1) << len_code[1:0]) - COL_W'(1);
  end

  assign low_seq    = base_q + cnt_q;
  assign low_il     = base_q ^ cnt_q;
  assign beat_col   = (base_q & ~mask_q) | ((il_q ? low_il : low_seq) & mask_q);
  assign beat_vld   = act_q;
  assign beat_last  = act_q & ~full_q & (cnt_q == mask_q);
  assign burst_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      il_q   <= 1'b0;
      full_q <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      done_q <= act_q & ~start & (term | beat_last);
      if (start) begin
        act_q  <= 1'b1;
        base_q <= start_col;
        cnt_q  <= '0;
        mask_q <= mask_in;
        il_q   <= ileave;
        full_q <= full_in;
      end else if (act_q) begin
        if (term || beat_last) act_q <= 1'b0;
        else                   cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end

endmodule

module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             term,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_vld,
  input logic             beat_last,
  input logic             burst_done
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_vld && beat_col == $past(start_col))); // R2
  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_vld); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !start) |=> (!beat_vld && burst_done)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done); // R8
  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && term && !start) |=> (!beat_vld && burst_done)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_vld && !start) |=> (!beat_vld && !burst_done)); // R9
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .term(term),
  .beat_col(beat_col), .beat_vld(beat_vld), .beat_last(beat_last),
  .burst_done(burst_done)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic       clk = 0, rst_n = 0, start = 0, ileave = 0, term = 0;
  logic [8:0] start_col = 0, beat_col;
  logic [2:0] len_code = 0;
  logic       beat_vld, beat_last, burst_done;
  int checks = 0, fails = 0, cycles = 0;

  int  m_s = 0, m_k = 0, m_len = 1;
  bit  m_act = 0, m_il = 0, m_full = 0, m_done = 0;

  burst_col_gen i_burst_col_gen (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int exp_col();
    int lo = m_s % m_len;
    int lw = m_il ? (lo ^ m_k) : ((lo + m_k) % m_len);
    return m_s - lo + lw;
  endfunction

  function automatic bit exp_last();
    return m_act && !m_full && (m_k == m_len - 1);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "valid", beat_vld, m_act);
    chk(tag, "last", beat_last, exp_last());
    chk(tag, "done", burst_done, m_done);
    if (m_act) chk(tag, "col", beat_col, exp_col());
  endtask

  task automatic cyc(input bit st, input int c, input int code, input bit il,
                     input bit tm, input string tag);
    bit lst;
    start = st; start_col = 9'(c); len_code = 3'(code); ileave = il; term = tm;
    @(posedge clk);
    lst = exp_last();
    m_done = m_act && !st && (tm || lst);
    if (st) begin
      m_act = 1; m_s = c; m_k = 0; m_il = il;
      m_full = (code >= 4) && !il;
      m_len = m_full ? 512 : (code >= 4 ? 8 : (1 << code));
    end else if (m_act) begin
      if (tm || lst) m_act = 0;
      else m_k = (m_k + 1) % m_len;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    // R2 R3: linear bounded bursts of every length
    for (int code = 0; code < 4; code++) begin
      cyc(1, 9'h1F5, code, 0, 0, "R2");
      idle(9, "R3");
    end
    // R5: interleaved bursts of every length
    for (int code = 0; code < 4; code++) begin
      cyc(1, 9'h0AE, code, 1, 0, "R5");
      idle(9, "R5");
    end
    // R6: interleaved with full-page code
    cyc(1, 9'h13B, 5, 1, 0, "R6");
    idle(9, "R6");
    // R4: full page wraps past 512 and runs until terminated
    cyc(1, 9'h1FC, 4, 0, 0, "R4");
    idle(520, "R4");
    cyc(0, 0, 0, 0, 1, "R4");
    idle(2, "R4");
    // R9: terminate mid-burst and while idle
    cyc(1, 9'h040, 3, 0, 0, "R9");
    idle(2, "R9");
    cyc(0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, 1, "R9");
    idle(2, "R9");
    // R7 R8: terminate on the last beat
    cyc(1, 9'h007, 1, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, "R8");
    idle(2, "R8");
    // R10: restart mid-burst, restart on last beat, start with terminate
    cyc(1, 9'h100, 3, 1, 0, "R10");
    idle(3, "R10");
    cyc(1, 9'h0F3, 2, 0, 0, "R10");
    idle(3, "R10");
    cyc(1, 9'h055, 0, 0, 0, "R10");
    cyc(1, 9'h056, 0, 0, 0, "R10");
    cyc(1, 9'h1C2, 2, 1, 1, "R10");
    idle(6, "R10");
    // R11: mode inputs changed during a burst are ignored
    cyc(1, 9'h0D9, 3, 0, 0, "R11");
    for (int i = 0; i < 9; i++) cyc(0, 0, (i % 2) ? 0 : 6, i % 2, 0, "R11");
    idle(2, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule